// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sequences a second-level cache made of external data SRAM and an external tag SRAM. One tag word is kept per line. It holds the stored address tag, a valid flag and a dirty flag, so no separate dirty store is needed. When the CPU makes a request, the controller latches the address. It reads the tag word at the line index and decides between hit and miss. It then either streams a four-word line out of the data SRAM, writes one word into it, or goes to the DRAM controller. The DRAM controller is reached through a request/acknowledge pair.

Read hits come out as four beats. The pacing depends on the bank setup. With two interleaved banks the clocks are 2-1-1-1, with one bank they are 2-2-2-2, and with slow SRAM they are 3-2-2-2. Write hits take one wait state, or none when the fast-write strap is set. A read miss that lands on a dirty victim first copies the victim line back to DRAM and then fills the new line. After the fill it replays the tag check, so the CPU receives the line as an ordinary hit. A write miss goes to DRAM as a single word and does not allocate a line.

A separate input signals that the CPU's own cache holds a modified copy. While this input is high, the controller cancels the cycle in progress and parks. When the input drops, it replays the same request from the tag check.

Top module: `cachectl_wb`

## Requirements
- R1: After reset the controller is idle, and cpu_rdy, cpu_last, dram_req, tag_we, sram_we and sram_oe are all low.
- R2: A CPU address is split as {tag, index, word}, with the word offset in the two lowest bits. The tag word read from tag SRAM has the dirty flag in its top bit, the valid flag in the next bit, and the stored tag in the low TAG_W bits. The index is presented on tag_idx. A hit requires the valid flag to be set and the stored tag to equal the address tag.
- R3: A request is accepted at a clock edge; cycle n is the n-th clock period after that edge. With two_bank=1 and slow_sram=0, a read hit raises cpu_rdy in cycles 2, 3, 4 and 5. sram_bank equals the beat number's low bit (0,1,0,1).
- R4: With two_bank=0 and slow_sram=0, a read hit raises cpu_rdy in cycles 2, 4, 6 and 8, with sram_bank held at 0.
- R5: With slow_sram=1, a read hit raises cpu_rdy in cycles 3, 5, 7 and 9, whatever the bank count.
- R6: With fast_write=0, a write hit gives a single cpu_rdy in cycle 2. In the same cycle it pulses sram_we and writes the tag word back with both the dirty and valid flags set.
- R7: With fast_write=1, a write hit completes the same way but in cycle 1.
- R8: A write miss issues exactly one DRAM request, with dram_wr=1, dram_line=0 and dram_addr equal to the full word address. It leaves the tag word unchanged and gives one cpu_rdy.
- R9: A read miss whose victim is valid and dirty first issues a line write-back: dram_wr=1, dram_line=1, dram_addr={victim tag, index, 0}. It then issues a line fill: dram_wr=0, dram_line=1, dram_addr={new tag, index, 0}.
- R10: When a fill is acknowledged, the tag word is written as dirty=0, valid=1, new tag. A clean or invalid victim goes straight to the fill. After the fill, the CPU receives the full four-beat burst.
- R11: While abort_in is high, cpu_rdy, dram_req, tag_we, sram_we and sram_oe stay low. When abort_in drops, the same request restarts from the tag check, and a read burst starts again from beat 0.
- R12: Once raised, dram_req stays high with a stable dram_addr until dram_ack, unless the request is aborted.
- R13: cpu_last is high together with the final cpu_rdy of each transaction: the fourth beat of a read, or the single beat of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request strobe, sampled while idle |
| cpu_we | input | 1 | 1 = write request |
| cpu_addr | input | AW | Word address {tag, index, word} |
| cpu_rdy | output | 1 | One data beat done |
| cpu_last | output | 1 | Final beat of the transaction |
| abort_in | input | 1 | CPU holds a modified copy; cancel and replay |
| two_bank | input | 1 | Two interleaved data banks fitted |
| slow_sram | input | 1 | Add a clock to the first read beat and pace at two |
| fast_write | input | 1 | Zero-wait write hits |
| tag_idx | output | IDX_W | Tag SRAM index |
| tag_rdata | input | TAG_W+2 | Tag word {dirty, valid, tag} |
| tag_we | output | 1 | Tag word write strobe |
| tag_wdata | output | TAG_W+2 | Tag word to write |
| sram_oe | output | 1 | Data SRAM read enable |
| sram_we | output | 1 | Data SRAM write enable |
| sram_word | output | OFF_W | Word within line |
| sram_bank | output | 1 | Data bank select |
| dram_req | output | 1 | DRAM request |
| dram_wr | output | 1 | 1 = write to DRAM |
| dram_line | output | 1 | 1 = whole line, 0 = single word |
| dram_addr | output | AW | DRAM word address |
| dram_ack | input | 1 | DRAM done, one-cycle pulse |

## Verification
The bench builds the controller with TAG_W=6, IDX_W=3 and OFF_W=2. The small index keeps the tag SRAM model at eight words, so one test can preload a victim line and later read back the exact tag word the controller wrote. The narrow tag makes the dirty, valid and tag fields easy to tell apart in a printed value. The four-beat line is kept, so all three pacing patterns and the bank alternation show up beat by beat. The DRAM model answers after a fixed delay, which leaves room to raise the abort input during a fill and observe the replayed request.

// File: rtl/cachectl_pkg.sv
package cachectl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TAG_CHECK,
    S_READ_BURST,
    S_WRITE_HIT,
    S_WRITEBACK,
    S_LINE_FILL,
    S_MISS_WRITE,
    S_ABORT_WAIT
  } cc_state_e;

  // extra clocks before the first read beat
  function automatic logic [1:0] lead_wait(input logic slow);
    return slow ? 2'd1 : 2'd0;
  endfunction

  // extra clocks between later read beats
  function automatic logic [1:0] gap_wait(input logic two_bank, input logic slow);
    return (two_bank && !slow) ? 2'd0 : 2'd1;
  endfunction

endpackage

// File: rtl/cachectl_tagcmp.sv
module cachectl_tagcmp #(
  parameter int TAG_W = 8
) (
  input  logic [TAG_W+1:0] tag_word,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit,
  output logic             victim_dirty,
  output logic [TAG_W-1:0] victim_tag
);
  localparam int VALID_BIT = TAG_W;
  localparam int DIRTY_BIT = TAG_W + 1;

  assign victim_tag   = tag_word[TAG_W-1:0];
  assign hit          = tag_word[VALID_BIT] && (victim_tag == req_tag);
  assign victim_dirty = tag_word[VALID_BIT] && tag_word[DIRTY_BIT];
endmodule

// File: rtl/cachectl_burst.sv
module cachectl_burst
  import cachectl_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic             two_bank,
  input  logic             slow,
  output logic             beat_rdy,
  output logic [OFF_W-1:0] beat,
  output logic             beat_last
);
  logic [1:0]       wcnt;
  logic [OFF_W-1:0] beat_q;

  assign beat_rdy  = run && (wcnt == 2'd0);
  assign beat      = beat_q;
  assign beat_last = beat_rdy && (beat_q == {OFF_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt   <= 2'd0;
      beat_q <= '0;
    end else if (load) begin
      wcnt   <= lead_wait(slow);
      beat_q <= '0;
    end else if (run) begin
      if (wcnt == 2'd0) begin
        beat_q <= beat_q + 1'b1;
        wcnt   <= gap_wait(two_bank, slow);
      end else begin
        wcnt <= wcnt - 2'd1;
      end
    end
  end
endmodule

// File: rtl/cachectl_fsm.sv
module cachectl_fsm
  import cachectl_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int IDX_W = 6,
  parameter int OFF_W = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cpu_req,
  input  logic                           cpu_we,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]   cpu_addr,
  input  logic                           abort_in,
  input  logic                           fast_write,
  input  logic                           two_bank,
  input  logic                           hit,
  input  logic                           victim_dirty,
  input  logic [TAG_W-1:0]               victim_tag,
  input  logic                           beat_rdy,
  input  logic                           beat_last,
  input  logic [OFF_W-1:0]               beat,
  input  logic                           dram_ack,
  output cc_state_e                      state,
  output logic [TAG_W-1:0]               q_tag,
  output logic [IDX_W-1:0]               q_idx,
  output logic                           burst_load,
  output logic                           burst_run,
  output logic                           ev_wr_hit,
  output logic                           ev_fill_done,
  output logic                           cpu_rdy,
  output logic                           cpu_last,
  output logic [OFF_W-1:0]               sram_word,
  output logic                           sram_bank,
  output logic                           dram_req,
  output logic                           dram_wr,
  output logic                           dram_line,
  output logic [TAG_W+IDX_W+OFF_W-1:0]   dram_addr
);
  localparam int AW = TAG_W + IDX_W + OFF_W;

  cc_state_e        nxt;
  logic [AW-1:0]    q_addr;
  logic             q_we;
  logic [OFF_W-1:0] q_off;
  logic             live;
  logic             ev_mw_done;

  assign q_tag = q_addr[AW-1 -: TAG_W];
  assign q_idx = q_addr[OFF_W +: IDX_W];
  assign q_off = q_addr[OFF_W-1:0];
  assign live  = !abort_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      q_addr <= '0;
      q_we   <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && cpu_req) begin
        q_addr <= cpu_addr;
        q_we   <= cpu_we;
      end
    end
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:       if (cpu_req) nxt = S_TAG_CHECK;
      S_TAG_CHECK: begin
        if (hit) nxt = q_we ? (fast_write ? S_IDLE : S_WRITE_HIT) : S_READ_BURST;
        else     nxt = q_we ? S_MISS_WRITE : (victim_dirty ? S_WRITEBACK : S_LINE_FILL);
      end
      S_READ_BURST: if (beat_last) nxt = S_IDLE;
      S_WRITE_HIT:  nxt = S_IDLE;
      S_WRITEBACK:  if (dram_ack) nxt = S_LINE_FILL;
      S_LINE_FILL:  if (dram_ack) nxt = S_TAG_CHECK;
      S_MISS_WRITE: if (dram_ack) nxt = S_IDLE;
      S_ABORT_WAIT: if (!abort_in) nxt = S_TAG_CHECK;
      default:      nxt = S_IDLE;
    endcase
    if (abort_in && state != S_IDLE && state != S_ABORT_WAIT) nxt = S_ABORT_WAIT;
  end

  assign ev_wr_hit    = live && ((state == S_TAG_CHECK && q_we && hit && fast_write)
                                 || state == S_WRITE_HIT);
  assign ev_fill_done = live && state == S_LINE_FILL && dram_ack;
  assign ev_mw_done   = live && state == S_MISS_WRITE && dram_ack;

  assign burst_load = (state != S_READ_BURST);
  assign burst_run  = live && (state == S_READ_BURST);

  assign cpu_rdy  = beat_rdy || ev_wr_hit || ev_mw_done;
  assign cpu_last = beat_last || ev_wr_hit || ev_mw_done;

  assign sram_word = (state == S_READ_BURST) ? beat : q_off;
  assign sram_bank = two_bank ? sram_word[0] : 1'b0;

  assign dram_req  = live && (state == S_WRITEBACK || state == S_LINE_FILL
                              || state == S_MISS_WRITE);
  assign dram_wr   = (state == S_WRITEBACK) || (state == S_MISS_WRITE);
  assign dram_line = (state != S_MISS_WRITE);

  always_comb begin
    case (state)
      S_WRITEBACK:  dram_addr = {victim_tag, q_idx, {OFF_W{1'b0}}};
      S_MISS_WRITE: dram_addr = q_addr;
      default:      dram_addr = {q_tag, q_idx, {OFF_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/cachectl_wb.sv
module cachectl_wb
  import cachectl_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int IDX_W = 6,
  parameter int OFF_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [TAG_W+IDX_W+OFF_W-1:0] cpu_addr,
  output logic                         cpu_rdy,
  output logic                         cpu_last,
  input  logic                         abort_in,
  input  logic                         two_bank,
  input  logic                         slow_sram,
  input  logic                         fast_write,
  output logic [IDX_W-1:0]             tag_idx,
  input  logic [TAG_W+1:0]             tag_rdata,
  output logic                         tag_we,
  output logic [TAG_W+1:0]             tag_wdata,
  output logic                         sram_oe,
  output logic                         sram_we,
  output logic [OFF_W-1:0]             sram_word,
  output logic                         sram_bank,
  output logic                         dram_req,
  output logic                         dram_wr,
  output logic                         dram_line,
  output logic [TAG_W+IDX_W+OFF_W-1:0] dram_addr,
  input  logic                         dram_ack
);
  localparam int AW = TAG_W + IDX_W + OFF_W;

  cc_state_e        state;
  logic [TAG_W-1:0] q_tag;
  logic [TAG_W-1:0] victim_tag;
  logic             hit, victim_dirty;
  logic             burst_load, burst_run;
  logic             beat_rdy, beat_last;
  logic [OFF_W-1:0] beat;
  logic             ev_wr_hit, ev_fill_done;

  cachectl_tagcmp #(.TAG_W(TAG_W)) u_cmp (
    .tag_word     (tag_rdata),
    .req_tag      (q_tag),
    .hit          (hit),
    .victim_dirty (victim_dirty),
    .victim_tag   (victim_tag)
  );

  cachectl_burst #(.OFF_W(OFF_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (burst_load),
    .run       (burst_run),
    .two_bank  (two_bank),
    .slow      (slow_sram),
    .beat_rdy  (beat_rdy),
    .beat      (beat),
    .beat_last (beat_last)
  );

  cachectl_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .abort_in     (abort_in),
    .fast_write   (fast_write),
    .two_bank     (two_bank),
    .hit          (hit),
    .victim_dirty (victim_dirty),
    .victim_tag   (victim_tag),
    .beat_rdy     (beat_rdy),
    .beat_last    (beat_last),
    .beat         (beat),
    .dram_ack     (dram_ack),
    .state        (state),
    .q_tag        (q_tag),
    .q_idx        (tag_idx),
    .burst_load   (burst_load),
    .burst_run    (burst_run),
    .ev_wr_hit    (ev_wr_hit),
    .ev_fill_done (ev_fill_done),
    .cpu_rdy      (cpu_rdy),
    .cpu_last     (cpu_last),
    .sram_word    (sram_word),
    .sram_bank    (sram_bank),
    .dram_req     (dram_req),
    .dram_wr      (dram_wr),
    .dram_line    (dram_line),
    .dram_addr    (dram_addr)
  );

  assign sram_oe   = (state == S_READ_BURST) && !abort_in;
  assign sram_we   = ev_wr_hit;
  assign tag_we    = ev_wr_hit || ev_fill_done;
  assign tag_wdata = {ev_wr_hit, 1'b1, q_tag};
endmodule

// File: rtl/cachectl_wb_chk.sv
module cachectl_wb_chk
  import cachectl_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int AW    = 16
) (
  input logic            clk,
  input logic            rst_n,
  input cc_state_e       state,
  input logic            abort_in,
  input logic            cpu_rdy,
  input logic            cpu_last,
  input logic            sram_oe,
  input logic            sram_we,
  input logic            tag_we,
  input logic [TAG_W+1:0] tag_wdata,
  input logic            dram_req,
  input logic            dram_ack,
  input logic [AW-1:0]   dram_addr,
  input logic            two_bank,
  input logic            slow_sram,
  input logic            fast_write,
  input logic            ev_wr_hit,
  input logic            ev_fill_done
);
  // R11
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_in |-> !cpu_rdy && !dram_req && !sram_we && !tag_we && !sram_oe);

  // R11
  abort_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_in && state != S_IDLE) |=> state == S_ABORT_WAIT);

  // R12
  dram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_req && !dram_ack && !abort_in) |=> (dram_req && $stable(dram_addr)) || abort_in);

  // R3
  pace_two_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdy && sram_oe && !cpu_last && two_bank && !slow_sram) |=> cpu_rdy || abort_in);

  // R4
  pace_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdy && sram_oe && !cpu_last && (!two_bank || slow_sram)) |=> !cpu_rdy);

  // R7
  no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TAG_CHECK && !fast_write) |-> !cpu_rdy);

  // R10
  fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |-> tag_we && tag_wdata[TAG_W+1:TAG_W] == 2'b01);

  // R6
  hit_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_hit |-> sram_we && cpu_last && tag_wdata[TAG_W+1:TAG_W] == 2'b11);
endmodule

bind cachectl_wb cachectl_wb_chk #(.TAG_W(TAG_W), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state        (state),
  .abort_in     (abort_in),
  .cpu_rdy      (cpu_rdy),
  .cpu_last     (cpu_last),
  .sram_oe      (sram_oe),
  .sram_we      (sram_we),
  .tag_we       (tag_we),
  .tag_wdata    (tag_wdata),
  .dram_req     (dram_req),
  .dram_ack     (dram_ack),
  .dram_addr    (dram_addr),
  .two_bank     (two_bank),
  .slow_sram    (slow_sram),
  .fast_write   (fast_write),
  .ev_wr_hit    (ev_wr_hit),
  .ev_fill_done (ev_fill_done)
);

// File: tb/sim_cachectl_wb.sv
module sim_cachectl_wb;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 6;
  localparam int IDX_W = 3;
  localparam int OFF_W = 2;
  localparam int AW    = TAG_W + IDX_W + OFF_W;
  localparam int DLAT  = 2;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             rst_n = 1'b0;
  logic             cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0]    cpu_addr = '0;
  logic             cpu_rdy, cpu_last;
  logic             abort_in = 1'b0;
  logic             two_bank = 1'b1, slow_sram = 1'b0, fast_write = 1'b0;
  logic [IDX_W-1:0] tag_idx;
  logic [TAG_W+1:0] tag_rdata;
  logic             tag_we;
  logic [TAG_W+1:0] tag_wdata;
  logic             sram_oe, sram_we, sram_bank;
  logic [OFF_W-1:0] sram_word;
  logic             dram_req, dram_wr, dram_line;
  logic [AW-1:0]    dram_addr;
  logic             dram_ack = 1'b0;

  cachectl_wb #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_rdy(cpu_rdy), .cpu_last(cpu_last), .abort_in(abort_in), .two_bank(two_bank),
    .slow_sram(slow_sram), .fast_write(fast_write), .tag_idx(tag_idx), .tag_rdata(tag_rdata),
    .tag_we(tag_we), .tag_wdata(tag_wdata), .sram_oe(sram_oe), .sram_we(sram_we),
    .sram_word(sram_word), .sram_bank(sram_bank), .dram_req(dram_req), .dram_wr(dram_wr),
    .dram_line(dram_line), .dram_addr(dram_addr), .dram_ack(dram_ack)
  );

  // tag SRAM model: asynchronous read, clocked write
  logic [TAG_W+1:0] tagmem [0:(1<<IDX_W)-1];
  assign tag_rdata = tagmem[tag_idx];
  always @(posedge clk) if (tag_we) tagmem[tag_idx] <= tag_wdata;

  // DRAM model: acknowledge after a fixed delay
  int dcnt = 0;
  always @(posedge clk) begin
    dram_ack <= 1'b0;
    if (dram_req && !dram_ack) begin
      if (dcnt == DLAT) begin dram_ack <= 1'b1; dcnt <= 0; end
      else dcnt <= dcnt + 1;
    end else dcnt <= 0;
  end

  // request log
  int   n_req = 0;
  int   log_addr [0:31];
  logic log_wr   [0:31];
  logic log_line [0:31];
  logic mq = 1'b0, ma = 1'b0;
  always @(negedge clk) begin
    if (dram_req && (!mq || ma)) begin
      log_addr[n_req % 32] = int'(dram_addr);
      log_wr[n_req % 32]   = dram_wr;
      log_line[n_req % 32] = dram_line;
      n_req = n_req + 1;
    end
    mq = dram_req;
    ma = dram_ack;
  end

  int n_chk = 0, n_err = 0;
  int n_rdy, viol, tw, drop;
  int rdy_cyc [0:7];
  logic rdy_bank [0:7];
  bit lastseen;

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int t, input int i, input int o);
    logic [TAG_W-1:0] tt = t[TAG_W-1:0];
    logic [IDX_W-1:0] ii = i[IDX_W-1:0];
    logic [OFF_W-1:0] oo = o[OFF_W-1:0];
    return {tt, ii, oo};
  endfunction

  function automatic int tword(input int d, input int v, input int t);
    return (d << (TAG_W+1)) | (v << TAG_W) | t;
  endfunction

  function automatic int exp_cyc(input int k, input bit two, input bit slow);
    int first = slow ? 3 : 2;
    int gap   = (two && !slow) ? 1 : 2;
    return first + k * gap;
  endfunction

  task automatic set_tag(input int i, input int w);
    @(negedge clk);
    tagmem[i] <= w[TAG_W+1:0];
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic we);
    @(negedge clk);
    cpu_addr = a; cpu_we = we; cpu_req = 1'b1;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  // walks cycles 1..maxc after acceptance, abort high in cycles [af, at)
  task automatic collect(input int af, input int at, input int maxc);
    logic p_req = 1'b0, p_ack = 1'b0, p_ab = 1'b0;
    logic [AW-1:0] p_addr = '0;
    n_rdy = 0; viol = 0; tw = 0; drop = 0; lastseen = 0;
    for (int c = 1; c <= maxc; c++) begin
      if (c > 1) @(negedge clk);
      abort_in = (c >= af && c < at);
      #1;
      if (abort_in && (cpu_rdy || dram_req || tag_we || sram_we || sram_oe)) viol++;
      if (p_req && !p_ack && !p_ab && !abort_in && (!dram_req || dram_addr != p_addr)) drop++;
      p_req = dram_req; p_ack = dram_ack; p_ab = abort_in; p_addr = dram_addr;
      if (tag_we) tw++;
      if (cpu_rdy) begin
        if (n_rdy < 8) begin rdy_cyc[n_rdy] = c; rdy_bank[n_rdy] = sram_bank; end
        n_rdy++;
        if (cpu_last) begin lastseen = 1; break; end
      end
    end
    abort_in = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk_eq("R1 outputs idle after reset",
           int'({cpu_rdy, cpu_last, dram_req, tag_we, sram_we, sram_oe}), 0);
  endtask

  task automatic t_read_hit(input bit two, input bit slow, input string req, input int idx);
    two_bank = two; slow_sram = slow;
    set_tag(idx, tword(0, 1, 21));
    issue(mk(21, idx, 1), 1'b0);
    chk_eq("R2 tag_idx carries index", int'(tag_idx), idx);
    collect(0, 0, 30);
    chk_eq({req, " beat count"}, n_rdy, 4);
    chk_eq("R13 cpu_last on fourth beat", int'(lastseen), 1);
    for (int k = 0; k < 4; k++) begin
      chk_eq({req, " beat cycle"}, rdy_cyc[k], exp_cyc(k, two, slow));
      if (!slow) chk_eq(two ? "R3 bank alternates" : "R4 bank fixed",
                        int'(rdy_bank[k]), two ? (k % 2) : 0);
    end
  endtask

  task automatic t_write_hit(input bit fast, input string req);
    two_bank = 1; slow_sram = 0; fast_write = fast;
    set_tag(2, tword(0, 1, 9));
    issue(mk(9, 2, 3), 1'b1);
    collect(0, 0, 10);
    chk_eq({req, " single ready"}, n_rdy, 1);
    chk_eq({req, " ready cycle"}, rdy_cyc[0], fast ? 1 : 2);
    chk_eq({req, " one tag write"}, tw, 1);
    chk_eq("R13 cpu_last on write", int'(lastseen), 1);
    @(negedge clk);
    chk_eq({req, " tag marked dirty"}, int'(tagmem[2]), tword(1, 1, 9));
    fast_write = 0;
  endtask

  task automatic t_write_miss();
    int base;
    set_tag(4, tword(1, 1, 7));
    base = n_req;
    issue(mk(40, 4, 2), 1'b1);
    collect(0, 0, 40);
    chk_eq("R8 one DRAM request", n_req - base, 1);
    chk_eq("R8 word address", log_addr[base % 32], int'(mk(40, 4, 2)));
    chk_eq("R8 write single", int'({log_wr[base % 32], log_line[base % 32]}), 2);
    chk_eq("R8 no tag write", tw, 0);
    chk_eq("R8 one ready", n_rdy, 1);
    @(negedge clk);
    chk_eq("R8 tag unchanged", int'(tagmem[4]), tword(1, 1, 7));
  endtask

  task automatic t_dirty_miss();
    int base;
    two_bank = 1; slow_sram = 0;
    set_tag(6, tword(1, 1, 12));
    base = n_req;
    issue(mk(33, 6, 0), 1'b0);
    collect(0, 0, 60);
    chk_eq("R9 two DRAM requests", n_req - base, 2);
    chk_eq("R9 write-back address", log_addr[base % 32], int'(mk(12, 6, 0)));
    chk_eq("R9 write-back is line write",
           int'({log_wr[base % 32], log_line[base % 32]}), 3);
    chk_eq("R9 fill address", log_addr[(base+1) % 32], int'(mk(33, 6, 0)));
    chk_eq("R9 fill is line read",
           int'({log_wr[(base+1) % 32], log_line[(base+1) % 32]}), 1);
    chk_eq("R10 burst after fill", n_rdy, 4);
    chk_eq("R12 request held", drop, 0);
    @(negedge clk);
    chk_eq("R10 tag after fill", int'(tagmem[6]), tword(0, 1, 33));
  endtask

  task automatic t_invalid_miss();
    int base;
    set_tag(1, tword(1, 0, 17));
    base = n_req;
    issue(mk(17, 1, 0), 1'b0);
    collect(0, 0, 60);
    chk_eq("R2 invalid entry misses, one request", n_req - base, 1);
    chk_eq("R10 clean victim goes to fill", int'(log_wr[base % 32]), 0);
    chk_eq("R10 burst after fill", n_rdy, 4);
  endtask

  task automatic t_abort_hit();
    two_bank = 1; slow_sram = 0;
    set_tag(3, tword(0, 1, 5));
    issue(mk(5, 3, 0), 1'b0);
    collect(2, 5, 40);
    chk_eq("R11 quiet while aborted", viol, 0);
    chk_eq("R11 full burst after replay", n_rdy, 4);
    for (int k = 0; k < 4; k++) chk_eq("R11 replay beat cycle", rdy_cyc[k], 7 + k);
  endtask

  task automatic t_abort_fill();
    int base;
    set_tag(5, tword(0, 1, 2));
    base = n_req;
    issue(mk(50, 5, 0), 1'b0);
    collect(3, 6, 60);
    chk_eq("R11 quiet during aborted fill", viol, 0);
    chk_eq("R11 fill reissued", n_req - base, 2);
    chk_eq("R11 reissued fill address", log_addr[(base+1) % 32], int'(mk(50, 5, 0)));
    chk_eq("R11 burst after replayed fill", n_rdy, 4);
    chk_eq("R12 request held", drop, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << IDX_W); i++) tagmem[i] <= '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_hit(1, 0, "R3", 5);
    t_read_hit(0, 0, "R4", 0);
    t_read_hit(1, 1, "R5", 7);
    t_read_hit(0, 1, "R5", 7);
    t_write_hit(0, "R6");
    t_write_hit(1, "R7");
    t_write_miss();
    t_dirty_miss();
    t_invalid_miss();
    t_abort_hit();
    t_abort_fill();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule